// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Engine

This block is a clock-synchronous model of the write front end of a byte-wide nonvolatile memory. It watches three active-low controls: chip select, output enable and write strobe. A write pulse that qualifies loads one byte into a page buffer. Further bytes for the same page may follow, as long as each new strobe starts before a load window runs out. When the window lapses with no strobe in progress, the engine runs a timed internal programming cycle. At the end of that cycle the buffered bytes are copied into a small behavioural storage array.

While programming is under way, reads return a status byte instead of stored data. On a read of the last written location, bit 7 is the inverse of the value written there. Bit 6 flips on every new read. The remaining bits carry the data. A busy output follows the programming state. A sticky error flag records any byte that was dropped because it named a different page from the first byte. Every time window is a parameter counted in clock cycles: the minimum strobe width, the byte-load window and the programming time.

Top module: `pgwr_engine`

## Requirements
- R1: A write strobe begins only at a clock edge that samples chip select low, write strobe low and output enable high. A strobe during which output enable is sampled low stores nothing, and stores nothing in later cycles either.
- R2: The address is taken at the edge where the later of chip select and write strobe is first sampled low. The data is taken at the edge where the earlier of the two is first sampled high again. Address or data changes at other times have no effect.
- R3: A strobe sampled low on fewer than MIN_LOW consecutive edges is discarded. A strobe sampled low on exactly MIN_LOW edges is stored.
- R4: Suppose no strobe follows. Busy then rises at the clock edge LOAD_WIN+1 cycles after the edge that started the last stored byte. A strobe in progress, including one held longer than the window, keeps programming from starting until it ends.
- R5: The page is address bits ADDR_W-1..PAGE_BITS. A byte whose page differs from that of the first byte in the current load is dropped, and page_err is set until reset. Bytes for the same page, including rewrites of one address, are merged, and the later value wins.
- R6: Busy stays high for exactly PROG_CYC cycles. When it falls, every loaded byte of the page is in the array. Bytes of the page that were not loaded keep their earlier values.
- R7: Write strobes that occur while busy is high store nothing, and they do not start a later programming cycle.
- R8: While busy is high, a read of the last written address returns the inverse of that byte's bit 7 and its bits 5..0. A read of any other address returns the array's bits 7 and 5..0.
- R9: While busy is high, bit 6 of the read data inverts at each new read, meaning an edge that samples chip select and output enable low after an edge that did not. Bit 6 holds steady during one continuous read.
- R10: dout_en goes high one edge after chip select and output enable are sampled low together. dout is zero whenever dout_en is low. Read data is registered. The array is indexed by the address modulo 2^(PAGE_BITS+ARR_PAGE_BITS), so higher pages alias.
- R11: After reset, busy, page_err and dout_en are low, and every array byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status byte |
| dout_en | output | 1 | Read data valid, drive enable for the bus |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | Sticky flag for a dropped off-page byte |

## Verification
Two functions can land on the same clock edge. One is the end of programming. The other is a read that is held open across it. The bench keeps chip select and output enable low on the last written address while busy falls. It then expects the sample taken as busy first reads low to still be the status byte, with bit 7 inverted and bit 6 unchanged within the read. The following sample must be the true byte. The bench also holds a strobe across the moment the load window would expire, and judges that busy stays low until the strobe has ended and the byte has merged into the same programming cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_PROG = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pgwr_strobe.sv
// Qualifies write strobes: start when both selects are low with output
// enable high, end when either select returns high; pulse length counted.
module pgwr_strobe #(
    parameter int ADDR_W  = 17,
    parameter int MIN_LOW = 2,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              strobe_on,
    output logic              ld_fire,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [7:0]        ld_data,
    output logic [CNT_W-1:0]  ld_len
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LOW_MIN = CNT_W'(MIN_LOW);

    typedef struct packed {
        logic              act;
        logic              spoil;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] adr;
    } stb_t;

    stb_t s_d, s_q;
    logic both_low;
    logic begin_now;

    always_comb begin
        both_low  = !ce_n && !we_n;
        begin_now = !s_q.act && both_low && oe_n;
        s_d       = s_q;
        ld_fire   = 1'b0;
        if (begin_now) begin
            s_d.act   = 1'b1;
            s_d.spoil = 1'b0;
            s_d.cnt   = CNT_W'(1);
            s_d.adr   = addr;
        end else if (s_q.act) begin
            if (both_low) begin
                if (s_q.cnt != CNT_MAX) begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
                if (!oe_n) begin
                    s_d.spoil = 1'b1;
                end
            end else begin
                s_d.act = 1'b0;
                ld_fire = !s_q.spoil && (s_q.cnt >= LOW_MIN);
            end
        end
        strobe_on = s_q.act || begin_now;
        ld_addr   = s_q.adr;
        ld_data   = din;
        ld_len    = s_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pgwr_seq.sv
// Load-window and programming-cycle sequencer.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int PAGE_BITS = 8,
    parameter int LOAD_WIN  = 20000,
    parameter int PROG_CYC  = 2000000,
    parameter int CNT_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strobe_on,
    input  logic                        ld_fire,
    input  logic [ADDR_W-1:0]           ld_addr,
    input  logic [7:0]                  ld_data,
    input  logic [CNT_W-1:0]            ld_len,
    output logic                        buf_we,
    output logic [PAGE_BITS-1:0]        buf_idx,
    output logic [7:0]                  buf_data,
    output logic                        commit,
    output logic [ADDR_W-PAGE_BITS-1:0] cur_page,
    output logic [ADDR_W-1:0]           last_addr,
    output logic [7:0]                  last_data,
    output logic                        busy,
    output logic                        page_err
);

    localparam int PG_W = ADDR_W - PAGE_BITS;
    localparam int PC_W = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] WIN_MAX   = '1;
    localparam logic [CNT_W-1:0] WIN_LIMIT = CNT_W'(LOAD_WIN);
    localparam logic [PC_W-1:0]  PROG_LAST = PC_W'(PROG_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [PG_W-1:0]   page;
        logic [ADDR_W-1:0] la;
        logic [7:0]        ldat;
        logic [CNT_W-1:0]  win;
        logic [PC_W-1:0]   prog;
        logic              err;
    } seq_t;

    seq_t q_d, q_q;
    logic same_page;

    always_comb begin
        q_d       = q_q;
        buf_we    = 1'b0;
        commit    = 1'b0;
        same_page = (ld_addr[ADDR_W-1:PAGE_BITS] == q_q.page);
        unique case (q_q.st)
            SEQ_IDLE: begin
                if (ld_fire) begin
                    buf_we   = 1'b1;
                    q_d.page = ld_addr[ADDR_W-1:PAGE_BITS];
                    q_d.la   = ld_addr;
                    q_d.ldat = ld_data;
                    q_d.win  = ld_len;
                    q_d.st   = SEQ_LOAD;
                end
            end
            SEQ_LOAD: begin
                if (ld_fire && same_page) begin
                    buf_we   = 1'b1;
                    q_d.la   = ld_addr;
                    q_d.ldat = ld_data;
                    q_d.win  = ld_len;
                end else begin
                    if (ld_fire) begin
                        q_d.err = 1'b1;
                    end
                    if ((q_q.win >= WIN_LIMIT) && !strobe_on) begin
                        q_d.st   = SEQ_PROG;
                        q_d.prog = '0;
                    end else if (q_q.win != WIN_MAX) begin
                        q_d.win = q_q.win + CNT_W'(1);
                    end
                end
            end
            SEQ_PROG: begin
                if (q_q.prog == PROG_LAST) begin
                    commit = 1'b1;
                    q_d.st = SEQ_IDLE;
                end else begin
                    q_d.prog = q_q.prog + PC_W'(1);
                end
            end
            default: q_d.st = SEQ_IDLE;
        endcase
        buf_idx   = ld_addr[PAGE_BITS-1:0];
        buf_data  = ld_data;
        cur_page  = q_q.page;
        last_addr = q_q.la;
        last_data = q_q.ldat;
        busy      = (q_q.st == SEQ_PROG);
        page_err  = q_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

endmodule

// File: rtl/pgwr_store.sv
// Page buffer with per-byte valid bits and the behavioural storage array.
module pgwr_store #(
    parameter int PAGE_BITS     = 8,
    parameter int ARR_PAGE_BITS = 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 buf_we,
    input  logic [PAGE_BITS-1:0]                 buf_idx,
    input  logic [7:0]                           buf_data,
    input  logic                                 commit,
    input  logic [ARR_PAGE_BITS-1:0]             commit_page,
    input  logic [PAGE_BITS+ARR_PAGE_BITS-1:0]   rd_idx,
    output logic [7:0]                           rd_data
);

    localparam int PAGE_BYTES = 1 << PAGE_BITS;
    localparam int ARR_AW     = PAGE_BITS + ARR_PAGE_BITS;
    localparam int ARR_BYTES  = 1 << ARR_AW;

    logic [7:0]            pbuf_d [PAGE_BYTES];
    logic [7:0]            pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_d, vld_q;
    logic [7:0]            mem_d  [ARR_BYTES];
    logic [7:0]            mem_q  [ARR_BYTES];

    always_comb begin
        pbuf_d = pbuf_q;
        vld_d  = vld_q;
        mem_d  = mem_q;
        if (buf_we) begin
            pbuf_d[buf_idx] = buf_data;
            vld_d[buf_idx]  = 1'b1;
        end
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (vld_q[i]) begin
                    mem_d[{commit_page, PAGE_BITS'(i)}] = pbuf_q[i];
                end
            end
            vld_d = '0;
        end
        rd_data = mem_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                pbuf_q[i] <= '0;
            end
        end else begin
            vld_q  <= vld_d;
            pbuf_q <= pbuf_d;
        end
    end

    for (genvar g = 0; g < ARR_BYTES; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

endmodule

// File: rtl/pgwr_rdpath.sv
// Registered read path with status substitution during programming.
module pgwr_rdpath #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [7:0]        last_data,
    input  logic [7:0]        arr_data,
    output logic [7:0]        dout,
    output logic              dout_en
);

    typedef struct packed {
        logic       rd_prev;
        logic       tog;
        logic       en;
        logic [7:0] dat;
    } rd_t;

    rd_t r_d, r_q;
    logic rd_now;
    logic tog_n;

    always_comb begin
        rd_now = !ce_n && !oe_n;
        r_d    = r_q;
        tog_n  = r_q.tog;
        if (busy && rd_now && !r_q.rd_prev) begin
            tog_n = ~r_q.tog;
        end
        r_d.tog     = tog_n;
        r_d.rd_prev = rd_now;
        r_d.en      = rd_now;
        if (!rd_now) begin
            r_d.dat = '0;
        end else if (!busy) begin
            r_d.dat = arr_data;
        end else if (addr == last_addr) begin
            r_d.dat = {~last_data[7], tog_n, last_data[5:0]};
        end else begin
            r_d.dat = {arr_data[7], tog_n, arr_data[5:0]};
        end
        dout    = r_q.dat;
        dout_en = r_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
    parameter int ADDR_W        = 17,
    parameter int PAGE_BITS     = 8,
    parameter int ARR_PAGE_BITS = 1,
    parameter int MIN_LOW       = 2,
    parameter int LOAD_WIN      = 20000,
    parameter int PROG_CYC      = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic              page_err
);

    localparam int WIN_TOP = (LOAD_WIN > MIN_LOW) ? LOAD_WIN : MIN_LOW;
    localparam int CNT_W   = $clog2(WIN_TOP + 2);
    localparam int PG_W    = ADDR_W - PAGE_BITS;
    localparam int ARR_AW  = PAGE_BITS + ARR_PAGE_BITS;

    logic              strobe_on, ld_fire;
    logic [ADDR_W-1:0] ld_addr;
    logic [7:0]        ld_data;
    logic [CNT_W-1:0]  ld_len;
    logic              buf_we, commit;
    logic [PAGE_BITS-1:0] buf_idx;
    logic [7:0]        buf_data;
    logic [PG_W-1:0]   cur_page;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        last_data;
    logic [7:0]        arr_data;

    pgwr_strobe #(.ADDR_W(ADDR_W), .MIN_LOW(MIN_LOW), .CNT_W(CNT_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .strobe_on(strobe_on), .ld_fire(ld_fire),
        .ld_addr(ld_addr), .ld_data(ld_data), .ld_len(ld_len)
    );

    pgwr_seq #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .LOAD_WIN(LOAD_WIN),
        .PROG_CYC(PROG_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe_on(strobe_on), .ld_fire(ld_fire),
        .ld_addr(ld_addr), .ld_data(ld_data), .ld_len(ld_len),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .commit(commit), .cur_page(cur_page), .last_addr(last_addr),
        .last_data(last_data), .busy(busy), .page_err(page_err)
    );

    pgwr_store #(.PAGE_BITS(PAGE_BITS), .ARR_PAGE_BITS(ARR_PAGE_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .commit(commit),
        .commit_page(cur_page[ARR_PAGE_BITS-1:0]),
        .rd_idx(addr[ARR_AW-1:0]), .rd_data(arr_data)
    );

    pgwr_rdpath #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .busy(busy), .last_addr(last_addr), .last_data(last_data),
        .arr_data(arr_data), .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
    parameter int PROG_CYC = 2000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic       busy,
    input logic       page_err
);

    logic [31:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 32'(PROG_CYC)));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 32'(PROG_CYC)));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(page_err) |-> page_err);

    assert_read_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n && !oe_n));

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

    assert_no_prog_mid_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ce_n || we_n || !oe_n));

endmodule

bind pgwr_engine pgwr_engine_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
);

// File: tb/pgwr_engine_test.sv
`timescale 1ns/1ps
module pgwr_engine_test;

    localparam int AW   = 7;
    localparam int PB   = 3;
    localparam int APB  = 2;
    localparam int MINL = 3;
    localparam int WIN  = 16;
    localparam int PROG = 30;
    localparam int NARR = 1 << (PB + APB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, busy, page_err;

    int total = 0;
    int bad = 0;
    int rises = 0;
    logic busy_prev = 1'b0;
    bit finished = 1'b0;
    logic [7:0] expm [NARR];

    always #2.5 clk = ~clk;

    pgwr_engine #(
        .ADDR_W(AW), .PAGE_BITS(PB), .ARR_PAGE_BITS(APB),
        .MIN_LOW(MINL), .LOAD_WIN(WIN), .PROG_CYC(PROG)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .busy(busy), .page_err(page_err)
    );

    always @(negedge clk) begin
        if (busy && !busy_prev) rises++;
        busy_prev = busy;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic pulse_wr(input logic [AW-1:0] a, input logic [7:0] d, input int low);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (low) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        din = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout; en = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_busy();
        for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input string tag);
        logic [7:0] v;
        logic en;
        rd(a, v, en);
        chk(v == expm[a[PB+APB-1:0]] && en, tag, v, expm[a[PB+APB-1:0]]);
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((p * 37 + i * 11 + 5) & 255);
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2, v3, vh;
        logic en;
        int k, n, r0;
        for (int i = 0; i < NARR; i++) expm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state R11
        chk(!busy && !page_err && !dout_en, "R11 reset outputs", {busy, page_err, dout_en}, 0);
        chk(dout == 8'h00, "R10 idle bus zero", dout, 0);
        expect_rd(7'h05, "R11 array zero");

        // R4 start timing, R6 duration, R3 exact MIN_LOW accepted
        addr = 7'h0A; din = 8'h5C; ce_n = 1'b0; we_n = 1'b0;
        k = 0;
        while (!busy && k < 200) begin
            @(negedge clk);
            k++;
            if (k == MINL) begin ce_n = 1'b1; we_n = 1'b1; end
            if (k == MINL + 1) din = '0;
        end
        chk(k == WIN + 2, "R4 busy start edge", k, WIN + 2);
        n = 0;
        while (busy && n < 200) begin @(negedge clk); n++; end
        chk(n == PROG, "R6 busy length", n, PROG);
        expm[8'h0A] = 8'h5C;
        expect_rd(7'h0A, "R6 single byte stored R3");

        // R8 / R9 status reads, R7 write during busy, held read across completion
        pulse_wr(7'h0B, 8'hA7, MINL);
        wait_busy();
        rd(7'h0B, v1, en);
        rd(7'h0B, v2, en);
        rd(7'h02, v3, en);
        chk(v1[7] == 1'b0 && v1[5:0] == 6'h27, "R8 last addr status", v1, 8'h27);
        chk(v1[6] != v2[6], "R9 toggle between reads", v2[6], !v1[6]);
        chk(v3[7] == expm[2][7] && v3[5:0] == expm[2][5:0], "R8 other addr status", v3, expm[2]);
        chk(v3[6] != v2[6], "R9 toggle third read", v3[6], !v2[6]);
        pulse_wr(7'h01, 8'h99, MINL);
        addr = 7'h0B; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        vh = dout;
        while (busy) begin
            @(negedge clk);
            if (busy) chk(dout == vh, "R9 steady within one read", dout, vh);
        end
        chk(dout[7] == 1'b0 && dout[6] == vh[6], "R8 status on completion edge", dout, vh);
        @(negedge clk);
        chk(dout == 8'hA7, "R8 true data after completion", dout, 8'hA7);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        chk(!dout_en && dout == 8'h00, "R10 bus released", {dout_en, dout}, 0);
        expm[8'h0B] = 8'hA7;
        r0 = rises;
        repeat (WIN + 10) @(negedge clk);
        chk(rises == r0 && !busy, "R7 no programming from busy write", rises, r0);
        expect_rd(7'h01, "R7 busy write dropped");

        // R2: select-controlled strobe, address at later fall, data at first rise
        addr = 7'h13; din = 8'h11; we_n = 1'b0; ce_n = 1'b1;
        repeat (2) @(negedge clk);
        addr = 7'h14; ce_n = 1'b0;
        @(negedge clk);
        addr = 7'h15;
        repeat (2) @(negedge clk);
        din = 8'h3C; ce_n = 1'b1;
        @(negedge clk);
        din = 8'hFF; we_n = 1'b1;
        @(negedge clk);
        wait_busy();
        wait_done();
        expm[8'h14] = 8'h3C;
        expect_rd(7'h14, "R2 address at later fall, data at first rise");
        expect_rd(7'h13, "R2 early address ignored");
        expect_rd(7'h15, "R2 late address ignored");

        // R3 short strobe, R1 inhibits
        r0 = rises;
        pulse_wr(7'h1C, 8'h77, MINL - 1);
        addr = 7'h1D; din = 8'h66; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        addr = 7'h1E; din = 8'h65; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (WIN + 10) @(negedge clk);
        chk(rises == r0, "R3 R1 no programming started", rises, r0);
        expect_rd(7'h1C, "R3 short strobe dropped");
        expect_rd(7'h1D, "R1 output enable low inhibits");
        expect_rd(7'h1E, "R1 output enable drop spoils strobe");

        // R4 window lapse gives two cycles; long strobe holds programming off
        r0 = rises;
        pulse_wr(7'h08, 8'h21, MINL);
        wait_busy(); wait_done();
        pulse_wr(7'h09, 8'h22, MINL);
        wait_busy(); wait_done();
        chk(rises == r0 + 2, "R4 lapsed window splits cycles", rises, r0 + 2);
        expm[8'h08] = 8'h21; expm[8'h09] = 8'h22;
        expect_rd(7'h08, "R4 first lapsed byte");
        expect_rd(7'h09, "R4 second lapsed byte");
        r0 = rises;
        pulse_wr(7'h10, 8'h31, MINL);
        repeat (WIN - 8) @(negedge clk);
        pulse_wr(7'h11, 8'h32, WIN + 4);
        chk(rises == r0 && !busy, "R4 held strobe delays programming", rises, r0);
        wait_busy(); wait_done();
        chk(rises == r0 + 1, "R4 held strobe merged", rises, r0 + 1);
        expm[8'h10] = 8'h31; expm[8'h11] = 8'h32;
        expect_rd(7'h10, "R4 merged byte a");
        expect_rd(7'h11, "R4 merged byte b");
        chk(page_err == 1'b0, "R5 no error without mismatch", page_err, 0);

        // R5 page mismatch, rewrite, partial page
        pulse_wr(7'h12, 8'h40, MINL); repeat (2) @(negedge clk);
        pulse_wr(7'h17, 8'h41, MINL); repeat (2) @(negedge clk);
        pulse_wr(7'h1A, 8'h55, MINL); repeat (2) @(negedge clk);
        chk(page_err == 1'b1, "R5 mismatch flagged", page_err, 1);
        pulse_wr(7'h12, 8'h42, MINL); repeat (2) @(negedge clk);
        pulse_wr(7'h10, 8'h43, MINL);
        wait_busy(); wait_done();
        expm[8'h12] = 8'h42; expm[8'h17] = 8'h41; expm[8'h10] = 8'h43;
        for (int a = 16; a < 24; a++) expect_rd(AW'(a), "R5 R6 page contents");
        expect_rd(7'h1A, "R5 off-page byte dropped");
        chk(page_err == 1'b1, "R5 flag sticky", page_err, 1);

        // full sweep of every page, then alias check R10
        for (int p = 0; p < (1 << APB); p++) begin
            for (int i = 0; i < (1 << PB); i++) begin
                pulse_wr(AW'(p * 8 + i), pat(p, i), MINL);
                @(negedge clk);
                expm[p * 8 + i] = pat(p, i);
            end
            wait_busy(); wait_done();
        end
        for (int a = 0; a < NARR; a++) expect_rd(AW'(a), "R6 sweep readback");
        for (int a = 0; a < NARR; a++) expect_rd(AW'(a + 32), "R10 alias readback");
        pulse_wr(7'h2A, 8'h9D, MINL);
        wait_busy(); wait_done();
        expm[8'h0A] = 8'h9D;
        expect_rd(7'h0A, "R10 aliased write lands");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule